// File: doc/BRIEF.md
# DMA Event Interrupt Status and Mask Unit

This block collects event pulses from a six-channel DMA engine and turns them into one level interrupt. It keeps two separate groups of sticky status bits, one for normal events and one for error events. Each group also has a mask. Software reads the status and mask words over a simple 32-bit word register bus and clears status bits by writing 1s to them.

A mask is never written directly. Each group has an unmask port and a mask port: writing 1s to the unmask port clears the matching mask bits, and writing 1s to the mask port sets them. The interrupt output is registered. It goes high when any status bit in either group is set and not masked.

The register bus carries a byte address, a write strobe, write data and combinational read data. Every access is a full 32-bit word.

Top module: `irq_split_ctl`

## Requirements
- R1: After reset both status words read 0, the normal mask reads 0x07FFFFFF, the error mask reads 0xFFFFFFFF, and irq_o is low.
- R2: Byte address 0x04 reads the normal status and 0x08 reads the normal mask. Byte address 0x14 reads the error status and 0x18 reads the error mask.
- R3: A write to a status address (0x04 normal, 0x14 error) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: A write to an unmask port (0x0C normal, 0x1C error) clears the mask bits written as 1. A write to a mask port (0x10 normal, 0x20 error) sets them. A write to a mask address (0x08 or 0x18) changes nothing.
- R5: The unmask and mask ports read as 0. Every address outside 0x04 to 0x20 reads as 0, and writes to those addresses change no state.
- R6: In the normal group, channel n (0 to 5) sets status bit n on desc_done_i[n] and bit 12+n on pyld_err_i[n]. vsync_i sets bit 27. No other normal bit is ever set.
- R7: In the error group, channel n sets bit 1+n on dfetch_err_i[n], bit 7+n on preamble_err_i[n], bit 13+n on crc_err_i[n] and bit 25+n on redone_err_i[n]. No other error bit is ever set.
- R8: If an event pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R9: irq_o is the value, one cycle earlier, of: (normal status AND NOT normal mask) is nonzero, or (error status AND NOT error mask) is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the word access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| desc_done_i | input | 6 | Per-channel descriptor completion pulse |
| pyld_err_i | input | 6 | Per-channel payload fetch failure pulse |
| vsync_i | input | 1 | Video sync event pulse |
| dfetch_err_i | input | 6 | Per-channel descriptor fetch failure pulse |
| preamble_err_i | input | 6 | Per-channel bad preamble pulse |
| crc_err_i | input | 6 | Per-channel descriptor checksum mismatch pulse |
| redone_err_i | input | 6 | Per-channel already-done descriptor pulse |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
The hardest case to reach is an event pulse and a software clear landing on the same bit in the same cycle. That is the point where the set-over-clear priority decides the outcome. A directed step sets a completion bit, then in one cycle writes a clear to that bit while the same channel pulses again.

Random stimulus adds sparse event pulses on every input while writes go to every address. This repeats the collision on many bit positions. Between steps the interrupt output is checked against unmask and mask changes.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int DW      = 32;
  localparam int AW      = 8;
  localparam int NCH     = 6;

  localparam logic [AW-1:0] OFS_N_ST  = 8'h04;
  localparam logic [AW-1:0] OFS_N_MK  = 8'h08;
  localparam logic [AW-1:0] OFS_N_EN  = 8'h0C;
  localparam logic [AW-1:0] OFS_N_DIS = 8'h10;
  localparam logic [AW-1:0] OFS_E_ST  = 8'h14;
  localparam logic [AW-1:0] OFS_E_MK  = 8'h18;
  localparam logic [AW-1:0] OFS_E_EN  = 8'h1C;
  localparam logic [AW-1:0] OFS_E_DIS = 8'h20;

  localparam logic [DW-1:0] N_MASK_RST = 32'h07FF_FFFF;
  localparam logic [DW-1:0] E_MASK_RST = 32'hFFFF_FFFF;

  // bit bases of each event class
  localparam int N_DONE_B  = 0;
  localparam int N_PYLD_B  = 12;
  localparam int N_VSYNC_B = 27;
  localparam int E_DFET_B  = 1;
  localparam int E_PREA_B  = 7;
  localparam int E_CRC_B   = 13;
  localparam int E_REDO_B  = 25;
endpackage

// File: rtl/irq_event_map.sv
module irq_event_map
  import irq_ctl_pkg::*;
(
  input  logic [NCH-1:0] desc_done_i,
  input  logic [NCH-1:0] pyld_err_i,
  input  logic           vsync_i,
  input  logic [NCH-1:0] dfetch_err_i,
  input  logic [NCH-1:0] preamble_err_i,
  input  logic [NCH-1:0] crc_err_i,
  input  logic [NCH-1:0] redone_err_i,
  output logic [DW-1:0]  set_n_o,
  output logic [DW-1:0]  set_e_o
);
  logic [DW-1:0] n_vec [NCH];
  logic [DW-1:0] e_vec [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      n_vec[c] = '0;
      n_vec[c][N_DONE_B + c] = desc_done_i[c];
      n_vec[c][N_PYLD_B + c] = pyld_err_i[c];
      e_vec[c] = '0;
      e_vec[c][E_DFET_B + c] = dfetch_err_i[c];
      e_vec[c][E_PREA_B + c] = preamble_err_i[c];
      e_vec[c][E_CRC_B  + c] = crc_err_i[c];
      e_vec[c][E_REDO_B + c] = redone_err_i[c];
    end
  end

  always_comb begin
    set_n_o = '0;
    set_e_o = '0;
    for (int c = 0; c < NCH; c++) begin
      set_n_o |= n_vec[c];
      set_e_o |= e_vec[c];
    end
    set_n_o[N_VSYNC_B] = vsync_i;
  end
endmodule

// File: rtl/irq_group.sv
module irq_group #(
  parameter int             W        = 32,
  parameter logic [W-1:0]   RST_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic         dis_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);
  logic [W-1:0] st_q, mk_q;
  logic [W-1:0] clr;

  assign clr = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      mk_q <= RST_MASK;
    end else begin
      st_q <= (st_q & ~clr) | set_i;  // set beats clear
      if (en_we_i)       mk_q <= mk_q & ~wdata_i;
      else if (dis_we_i) mk_q <= mk_q | wdata_i;
    end
  end

  assign status_o = st_q;
  assign mask_o   = mk_q;
  assign pend_o   = |(st_q & ~mk_q);
endmodule

// File: rtl/irq_split_ctl.sv
module irq_split_ctl
  import irq_ctl_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic           we_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic [NCH-1:0] desc_done_i,
  input  logic [NCH-1:0] pyld_err_i,
  input  logic           vsync_i,
  input  logic [NCH-1:0] dfetch_err_i,
  input  logic [NCH-1:0] preamble_err_i,
  input  logic [NCH-1:0] crc_err_i,
  input  logic [NCH-1:0] redone_err_i,
  output logic           irq_o
);
  logic [DW-1:0] set_n, set_e, st_n, mk_n, st_e, mk_e;
  logic          pend_n, pend_e, irq_q;

  irq_event_map u_map (
    .desc_done_i, .pyld_err_i, .vsync_i, .dfetch_err_i,
    .preamble_err_i, .crc_err_i, .redone_err_i,
    .set_n_o(set_n), .set_e_o(set_e)
  );

  irq_group #(.W(DW), .RST_MASK(N_MASK_RST)) u_grp_n (
    .clk_i, .rst_ni, .set_i(set_n),
    .clr_we_i(we_i && addr_i == OFS_N_ST),
    .en_we_i (we_i && addr_i == OFS_N_EN),
    .dis_we_i(we_i && addr_i == OFS_N_DIS),
    .wdata_i, .status_o(st_n), .mask_o(mk_n), .pend_o(pend_n)
  );

  irq_group #(.W(DW), .RST_MASK(E_MASK_RST)) u_grp_e (
    .clk_i, .rst_ni, .set_i(set_e),
    .clr_we_i(we_i && addr_i == OFS_E_ST),
    .en_we_i (we_i && addr_i == OFS_E_EN),
    .dis_we_i(we_i && addr_i == OFS_E_DIS),
    .wdata_i, .status_o(st_e), .mask_o(mk_e), .pend_o(pend_e)
  );

  always_comb begin
    unique case (addr_i)
      OFS_N_ST: rdata_o = st_n;
      OFS_N_MK: rdata_o = mk_n;
      OFS_E_ST: rdata_o = st_e;
      OFS_E_MK: rdata_o = mk_e;
      default:  rdata_o = '0;  // unmask/mask ports and holes read 0
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= pend_n | pend_e;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_split_ctl_chk.sv
module irq_split_ctl_chk
  import irq_ctl_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          we_i,
  input logic          irq_o,
  input logic [DW-1:0] set_n,
  input logic [DW-1:0] set_e,
  input logic [DW-1:0] st_n,
  input logic [DW-1:0] mk_n,
  input logic [DW-1:0] st_e,
  input logic [DW-1:0] mk_e
);
  localparam logic [DW-1:0] N_USED = 32'h0803_F03F;
  localparam logic [DW-1:0] E_USED = 32'h7E07_FFFE;

  logic mk_n_wr, mk_e_wr;
  assign mk_n_wr = we_i && (addr_i == OFS_N_EN || addr_i == OFS_N_DIS);
  assign mk_e_wr = we_i && (addr_i == OFS_E_EN || addr_i == OFS_E_DIS);

  // R9
  irq_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past((|(st_n & ~mk_n)) || (|(st_e & ~mk_e))));

  // R8
  set_wins_n_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_n != '0) |=> ((st_n & $past(set_n)) == $past(set_n)));

  // R8
  set_wins_e_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_e != '0) |=> ((st_e & $past(set_e)) == $past(set_e)));

  // R4
  mask_n_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mk_n_wr |=> $stable(mk_n));

  // R4
  mask_e_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mk_e_wr |=> $stable(mk_e));

  // R6
  unused_n_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_n & ~N_USED) == '0);

  // R7
  unused_e_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_e & ~E_USED) == '0);
endmodule

bind irq_split_ctl irq_split_ctl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .irq_o(irq_o),
  .set_n(set_n), .set_e(set_e), .st_n(st_n), .mk_n(mk_n), .st_e(st_e), .mk_e(mk_e)
);

// File: tb/irq_split_ctl_bench.sv
module irq_split_ctl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [5:0]  desc_done_i = '0, pyld_err_i = '0, dfetch_err_i = '0;
  logic [5:0]  preamble_err_i = '0, crc_err_i = '0, redone_err_i = '0;
  logic        vsync_i = 1'b0;
  logic        irq_o;

  int checks = 0, errors = 0;
  bit done_flag = 0;
  logic [31:0] m_st_n = '0, m_mk_n = 32'h07FF_FFFF, m_st_e = '0, m_mk_e = 32'hFFFF_FFFF;

  irq_split_ctl u_irq_split_ctl (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] map_n(logic [5:0] dd, logic [5:0] pe, logic vs);
    logic [31:0] b = '0;
    for (int c = 0; c < 6; c++) begin b[c] = dd[c]; b[12+c] = pe[c]; end
    b[27] = vs;
    return b;
  endfunction

  function automatic logic [31:0] map_e(logic [5:0] df, logic [5:0] pr, logic [5:0] cr, logic [5:0] ad);
    logic [31:0] b = '0;
    for (int c = 0; c < 6; c++) begin
      b[1+c] = df[c]; b[7+c] = pr[c]; b[13+c] = cr[c]; b[25+c] = ad[c];
    end
    return b;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h04: return m_st_n;
      8'h08: return m_mk_n;
      8'h14: return m_st_e;
      8'h18: return m_mk_e;
      default: return '0;
    endcase
  endfunction

  // one clock cycle; called at a negedge, returns at the next negedge
  task automatic cycle(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic [5:0] dd, pe, df, pr, cr, ad, input logic vs);
    logic exp_irq;
    we_i = we; addr_i = a; wdata_i = d;
    desc_done_i = dd; pyld_err_i = pe; vsync_i = vs;
    dfetch_err_i = df; preamble_err_i = pr; crc_err_i = cr; redone_err_i = ad;
    exp_irq = (|(m_st_n & ~m_mk_n)) || (|(m_st_e & ~m_mk_e));
    if (we) case (a)
      8'h04: m_st_n &= ~d;
      8'h0C: m_mk_n &= ~d;
      8'h10: m_mk_n |= d;
      8'h14: m_st_e &= ~d;
      8'h1C: m_mk_e &= ~d;
      8'h20: m_mk_e |= d;
      default: ;
    endcase
    m_st_n |= map_n(dd, pe, vs);
    m_st_e |= map_e(df, pr, cr, ad);
    @(posedge clk_i); @(negedge clk_i);
    chk(irq_o == exp_irq, "R9 irq", {31'b0, irq_o}, {31'b0, exp_irq});
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    we_i = 0; addr_i = a;
    desc_done_i = '0; pyld_err_i = '0; vsync_i = 0;
    dfetch_err_i = '0; preamble_err_i = '0; crc_err_i = '0; redone_err_i = '0;
    #1;
    chk(rdata_o === exp_read(a), req, rdata_o, exp_read(a));
  endtask

  task automatic rd_all(input string req);
    rd(8'h04, req); rd(8'h08, req); rd(8'h14, req); rd(8'h18, req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk_i);
    #1;
    chk(irq_o == 1'b0, "R1 irq in reset", {31'b0, irq_o}, 32'h0);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state, R2 address map
    rd(8'h04, "R1 normal status"); rd(8'h08, "R1 normal mask");
    rd(8'h14, "R1 error status");  rd(8'h18, "R1 error mask");
    chk(rdata_o == 32'hFFFF_FFFF, "R2 error mask addr", rdata_o, 32'hFFFF_FFFF);
    chk(irq_o == 1'b0, "R1 irq", {31'b0, irq_o}, 32'h0);

    // R6 normal event positions
    cycle(0, 8'h00, 0, 6'h04, 6'h20, 0, 0, 0, 0, 1);
    rd(8'h04, "R6 normal bits");
    chk(rdata_o == 32'h0802_0004, "R6 normal positions", rdata_o, 32'h0802_0004);
    cycle(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0); // irq from unmasked bit 27

    // R7 error event positions
    cycle(0, 8'h00, 0, 0, 0, 6'h01, 6'h20, 6'h08, 6'h20, 0);
    rd(8'h14, "R7 error bits");
    chk(rdata_o == 32'h4001_1002, "R7 error positions", rdata_o, 32'h4001_1002);

    // R3 write-1-to-clear
    cycle(1, 8'h04, 32'h0800_0000, 0, 0, 0, 0, 0, 0, 0);
    rd(8'h04, "R3 clear vsync");
    chk(rdata_o == 32'h0002_0004, "R3 others kept", rdata_o, 32'h0002_0004);
    cycle(1, 8'h14, 32'h0000_1002, 0, 0, 0, 0, 0, 0, 0);
    rd(8'h14, "R3 error clear");

    // R8 set beats clear on same bit
    cycle(1, 8'h04, 32'h0000_0004, 6'h04, 0, 0, 0, 0, 0, 0);
    rd(8'h04, "R8 set wins");
    chk(rdata_o[2] == 1'b1, "R8 bit2 held", rdata_o, 32'h0002_0004);

    // R4 mask writes
    cycle(1, 8'h08, 32'h0, 0, 0, 0, 0, 0, 0, 0);
    rd(8'h08, "R4 direct mask write ignored");
    cycle(1, 8'h0C, 32'h0000_0004, 0, 0, 0, 0, 0, 0, 0);
    rd(8'h08, "R4 unmask");
    cycle(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(irq_o == 1'b1, "R9 irq after unmask", {31'b0, irq_o}, 32'h1);
    cycle(1, 8'h10, 32'h0000_0004, 0, 0, 0, 0, 0, 0, 0);
    cycle(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(irq_o == 1'b0, "R9 irq after remask", {31'b0, irq_o}, 32'h0);
    cycle(1, 8'h1C, 32'h4000_0000, 0, 0, 0, 0, 0, 0, 0);
    rd(8'h18, "R4 error unmask");
    cycle(1, 8'h18, 32'h0, 0, 0, 0, 0, 0, 0, 0);
    rd(8'h18, "R4 error direct write ignored");

    // R5 write-only ports and holes
    rd(8'h0C, "R5 unmask port reads 0"); rd(8'h10, "R5 mask port reads 0");
    rd(8'h1C, "R5 err unmask reads 0");  rd(8'h20, "R5 err mask reads 0");
    cycle(1, 8'h24, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0);
    cycle(1, 8'h00, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0);
    rd(8'h24, "R5 hole reads 0"); rd(8'h00, "R5 hole reads 0");
    rd_all("R5 state unchanged by hole writes");

    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a = 8'(($urandom % 10) * 4);
      logic [5:0] ev [6];
      for (int k = 0; k < 6; k++) ev[k] = ($urandom % 6 == 0) ? 6'($urandom) : 6'h0;
      cycle(($urandom % 2) == 0, a, $urandom, ev[0], ev[1], ev[2], ev[3], ev[4], ev[5],
            ($urandom % 10) == 0);
      rd(8'(($urandom % 10) * 4), "R2 random read");
    end
    rd_all("R3 R4 final state");

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule